// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block collects completion and error events from a set of DMA channel engines and turns them into software-visible interrupt state. Each channel owns one 32-bit control word that holds five enable bits, five sticky status bits and five write-one-to-clear command bits. The five events, in bit order, are: fragment finished, block finished, transaction finished, descriptor list finished, and configuration error. An event pulse is captured into its status bit only while the matching enable bit is set, and the captured bit holds until software clears it.

Two global summary words give one bit per channel. The raw summary shows which channels hold any status at all. The masked summary shows which channels hold at least one status bit whose enable is still set. A single level interrupt output is the OR of the masked summary. The block also reports which channel to service first and why: the lowest-numbered channel with a masked bit, and the most urgent status bit of that channel.

Registers are reached through a plain port: one address, one write strobe, write data and a combinational read data bus. The block has no state machine. Each channel word is a bank of flops updated in a single clock, and the summaries and the service pointer are combinational.

Top module: `dma_chan_irq_ctrl`

## Requirements
- R1: After reset every enable bit and every status bit is zero, `irq_o` is low, `irq_chan_o` and `irq_cause_o` are zero, and every register reads zero.
- R2: Channel c's control word sits at address CH_BASE + 4*c (default 0x40, 0x44, 0x48, 0x4C). A write loads bits 4:0 as enables: bit 0 fragment, bit 1 block, bit 2 transaction, bit 3 list, bit 4 configuration error. They read back in the same positions.
- R3: A one on event input `evt_i[c*5+k]` in a clock cycle sets status bit 16+k of channel c at that edge if enable bit k held one before the edge. With the enable at zero the pulse has no effect.
- R4: Status bits stay set until the channel word is written with a one in bit 24+k, which clears status bit 16+k. Writing zeros to bits 28:24, or any value to bits 20:16, leaves the status unchanged.
- R5: If a clear for a status bit and a gated event for that bit occur in the same cycle, the bit ends up set.
- R6: Bits 28:24 and every bit of a channel word outside 4:0 and 20:16 always read as zero.
- R7: The word at address 0x10 has bit c set exactly when channel c holds any status bit. All other bits are zero.
- R8: The word at address 0x14 has bit c set exactly when channel c holds a status bit whose enable bit is currently one.
- R9: `irq_o` is high exactly while the masked summary is nonzero, and it stays high for as long as that holds.
- R10: `irq_chan_o` gives the lowest channel with a masked bit. `irq_cause_o` encodes the highest-priority status bit of that channel: 5 configuration error, 4 list, 3 transaction, 2 block, 1 fragment. Both outputs are 0 while `irq_o` is low.
- R11: Addresses that map to no register read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | AW (8) | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_i | input | NCH*5 (20) | Event pulses, five per channel, channel c at bits c*5+4 : c*5 |
| irq_o | output | 1 | Level interrupt request |
| irq_chan_o | output | clog2(NCH) (2) | Channel to service first |
| irq_cause_o | output | 3 | Most urgent cause of that channel |

## Verification
The bench targets an event and a clear on the same bit in the same cycle. A design that lets the clear win would lose an event that arrived during servicing, and the channel word would read zero where one is expected. It also sends an event to a disabled bit and then clears an enable while its status is held. The first catches a design that latches without gating. The second catches a masked summary built from raw status, which would keep the interrupt asserted. Finally, it sets several bits on several channels together. A wrong priority order or a wrong channel scan order shows up as the wrong channel or cause code on the service outputs.

// File: rtl/dcirq_pkg.sv
package dcirq_pkg;

    localparam int NEV     = 5;
    localparam int EN_LSB  = 0;
    localparam int ST_LSB  = 16;
    localparam int CLR_LSB = 24;
    localparam int OFS_RAW = 'h10;
    localparam int OFS_MSK = 'h14;

    typedef logic [NEV-1:0] evvec_t;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_FRAG   = 3'd1,
        CAUSE_BLK    = 3'd2,
        CAUSE_TRANS  = 3'd3,
        CAUSE_LIST   = 3'd4,
        CAUSE_CFGERR = 3'd5
    } cause_e;

endpackage

// File: rtl/dcirq_chan.sv
module dcirq_chan
    import dcirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  evvec_t      wen_i,
    input  evvec_t      wclr_i,
    input  evvec_t      evt_i,
    output evvec_t      st_o,
    output logic        raw_o,
    output logic        msk_o,
    output logic [31:0] rdata_o
);

    evvec_t en_q;
    evvec_t st_q;
    evvec_t clr_v;
    evvec_t set_v;

    always_comb begin
        clr_v = wr_i ? wclr_i : '0;
        set_v = evt_i & en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (wr_i) en_q <= wen_i;
            st_q <= (st_q & ~clr_v) | set_v;
        end
    end

    always_comb begin
        rdata_o = '0;
        rdata_o[EN_LSB +: NEV] = en_q;
        rdata_o[ST_LSB +: NEV] = st_q;
        st_o  = st_q;
        raw_o = |st_q;
        msk_o = |(st_q & en_q);
    end

    // R3 / R5: a gated event is always captured, even against a clear
    p_evt_captured_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));

    // R3: no status bit rises without a gated event
    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(evt_i & en_q)) == '0));

    // R4: a status bit only falls when a clear was written for it
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_q & $past(st_q) & ~$past(clr_v)) == '0));

endmodule

// File: rtl/dcirq_cause_enc.sv
module dcirq_cause_enc
    import dcirq_pkg::*;
(
    input  evvec_t st_i,
    output cause_e cause_o
);

    always_comb begin
        cause_o = CAUSE_NONE;
        for (int k = 0; k < NEV; k++) begin
            if (st_i[k]) cause_o = cause_e'(3'(k + 1));
        end
    end

endmodule

// File: rtl/dcirq_aggr.sv
module dcirq_aggr
    import dcirq_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   msk_i,
    input  logic [NCH*NEV-1:0] st_i,
    output logic             irq_o,
    output logic [CW-1:0]    chan_o,
    output logic [2:0]       cause_o
);

    logic [CW-1:0] pick;
    evvec_t        pick_st;
    cause_e        enc_cause;

    always_comb begin
        pick = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (msk_i[c]) pick = CW'(c);
        end
        pick_st = st_i[pick*NEV +: NEV];
    end

    dcirq_cause_enc u_enc (
        .st_i    (pick_st),
        .cause_o (enc_cause)
    );

    always_comb begin
        irq_o   = |msk_i;
        chan_o  = irq_o ? pick : '0;
        cause_o = irq_o ? enc_cause : CAUSE_NONE;
    end

    // R10: a pending interrupt always carries a cause
    p_cause_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cause_o != CAUSE_NONE));

    // R10: the reported channel owns a masked bit
    p_chan_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> msk_i[chan_o]);

endmodule

// File: rtl/dma_chan_irq_ctrl.sv
module dma_chan_irq_ctrl
    import dcirq_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int AW      = 8,
    parameter int CH_BASE = 'h40,
    localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NCH*NEV-1:0] evt_i,
    output logic               irq_o,
    output logic [CW-1:0]      irq_chan_o,
    output logic [2:0]         irq_cause_o
);

    logic [NCH-1:0]     sel;
    logic [NCH-1:0]     raw;
    logic [NCH-1:0]     msk;
    logic [NCH*NEV-1:0] st_all;
    logic [31:0]        ch_rd [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign sel[c] = (reg_addr == AW'(CH_BASE + 4 * c));

        dcirq_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (reg_we && sel[c]),
            .wen_i   (reg_wdata[EN_LSB +: NEV]),
            .wclr_i  (reg_wdata[CLR_LSB +: NEV]),
            .evt_i   (evt_i[c*NEV +: NEV]),
            .st_o    (st_all[c*NEV +: NEV]),
            .raw_o   (raw[c]),
            .msk_o   (msk[c]),
            .rdata_o (ch_rd[c])
        );
    end

    dcirq_aggr #(.NCH(NCH)) u_aggr (
        .clk     (clk),
        .rst_n   (rst_n),
        .msk_i   (msk),
        .st_i    (st_all),
        .irq_o   (irq_o),
        .chan_o  (irq_chan_o),
        .cause_o (irq_cause_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_RAW)) reg_rdata[NCH-1:0] = raw;
        if (reg_addr == AW'(OFS_MSK)) reg_rdata[NCH-1:0] = msk;
        for (int c = 0; c < NCH; c++) begin
            if (sel[c]) reg_rdata = reg_rdata | ch_rd[c];
        end
    end

    // R9: the interrupt level agrees with the masked summary word
    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(OFS_MSK)) |-> ((reg_rdata != '0) == irq_o));

    // R8: masked summary never shows a channel absent from raw summary
    p_msk_in_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (u_aggr.msk_i & ~raw) == '0);

endmodule

// File: tb/dma_chan_irq_ctrl_tb_top.sv
module dma_chan_irq_ctrl_tb_top;

    localparam int NCH = 4;
    localparam int NE  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCH*NE-1:0] evt_i = '0;
    logic              irq_o;
    logic [1:0]        irq_chan_o;
    logic [2:0]        irq_cause_o;

    always #5 clk = ~clk;

    dma_chan_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .irq_o(irq_o), .irq_chan_o(irq_chan_o), .irq_cause_o(irq_cause_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [4:0] en_m [NCH];
    logic [4:0] st_m [NCH];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'h10) r[c] = |st_m[c];
            if (a == 8'h14) r[c] = |(st_m[c] & en_m[c]);
            if (a == 8'(8'h40 + 4 * c)) r = {11'b0, st_m[c], 11'b0, en_m[c]};
        end
        return r;
    endfunction

    task automatic compare_all();
        logic        e_irq = 1'b0;
        logic [1:0]  e_ch = '0;
        logic [2:0]  e_cause = '0;
        string       tag;
        for (int c = NCH - 1; c >= 0; c--) begin
            if ((st_m[c] & en_m[c]) != '0) begin
                e_irq = 1'b1;
                e_ch  = 2'(c);
            end
        end
        if (e_irq) begin
            for (int k = 0; k < NE; k++) if (st_m[e_ch][k]) e_cause = 3'(k + 1);
        end
        chk("R9 irq level", {31'b0, irq_o}, {31'b0, e_irq});
        chk("R10 channel", {30'b0, irq_chan_o}, {30'b0, e_ch});
        chk("R10 cause", {29'b0, irq_cause_o}, {29'b0, e_cause});
        if (reg_addr == 8'h10) tag = "R7 raw summary";
        else if (reg_addr == 8'h14) tag = "R8 masked summary";
        else if (reg_addr >= 8'h40 && reg_addr <= 8'h4C && reg_addr[1:0] == 2'b00)
            tag = "R2/R3/R4/R5/R6 channel word";
        else tag = "R11 unmapped read";
        chk(tag, reg_rdata, m_rd(reg_addr));
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [NCH*NE-1:0] ev);
        @(negedge clk);
        compare_all();
        reg_we = we; reg_addr = a; reg_wdata = d; evt_i = ev;
        for (int c = 0; c < NCH; c++) begin
            logic [4:0] setv = ev[c*NE +: NE] & en_m[c];
            if (we && a == 8'(8'h40 + 4 * c)) begin
                st_m[c] = (st_m[c] & ~d[28:24]) | setv;
                en_m[c] = d[4:0];
            end else begin
                st_m[c] = st_m[c] | setv;
            end
        end
    endtask

    function automatic logic [NCH*NE-1:0] ev_on(input int c, input logic [4:0] b);
        logic [NCH*NE-1:0] v = '0;
        v[c*NE +: NE] = b;
        return v;
    endfunction

    initial begin
        for (int c = 0; c < NCH; c++) begin en_m[c] = '0; st_m[c] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state on all outputs and a channel word
        reg_addr = 8'h44;
        #1 compare_all();
        reg_addr = 8'h10;
        #1 compare_all();
        rst_n = 1'b1;
        // R2: enable load and readback
        step(1, 8'h44, 32'h0000_0015, '0);
        step(0, 8'h44, '0, '0);
        // R3: all events on channel 1, only enabled ones latch
        step(0, 8'h44, '0, ev_on(1, 5'h1F));
        step(0, 8'h44, '0, '0);
        // R3: event on disabled channel 0 ignored
        step(0, 8'h40, '0, ev_on(0, 5'h1F));
        step(0, 8'h10, '0, '0);
        // R5: clear fragment status while a fragment event arrives
        step(1, 8'h44, 32'h0100_0015, ev_on(1, 5'h01));
        step(0, 8'h44, '0, '0);
        // R4: clear alone, writes to status field and zero clears are ignored
        step(1, 8'h44, 32'h001F_0015, '0);
        step(1, 8'h44, 32'h0100_0015, '0);
        step(0, 8'h44, '0, '0);
        // R8: dropping the enable keeps status but removes the masked bit
        step(1, 8'h44, 32'h0000_0000, '0);
        step(0, 8'h14, '0, '0);
        step(0, 8'h10, '0, '0);
        // R6: all-ones write reads back with clear bits zero
        step(1, 8'h48, 32'hFFFF_FFFF, '0);
        step(0, 8'h48, '0, '0);
        // R10: multiple channels and causes
        step(1, 8'h4C, 32'h0000_001F, '0);
        step(0, 8'h14, '0, ev_on(3, 5'h09) | ev_on(2, 5'h02));
        step(0, 8'h4C, '0, ev_on(2, 5'h10));
        step(0, 8'h48, '0, '0);
        // R11: unmapped address write and read
        step(1, 8'h3C, 32'hFFFF_FFFF, '0);
        step(0, 8'h3C, '0, '0);
        step(0, 8'h42, '0, '0);
        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            logic [NCH*NE-1:0] ev;
            int sel = $urandom_range(0, 9);
            if (sel < 6) a = 8'(8'h40 + 4 * $urandom_range(0, 3));
            else if (sel == 6) a = 8'h10;
            else if (sel == 7) a = 8'h14;
            else a = 8'($urandom_range(0, 255));
            d  = $urandom;
            ev = NCH*NE'($urandom) & NCH*NE'($urandom) & NCH*NE'($urandom);
            step(($urandom_range(0, 3) == 0), a, d, ev);
        end
        step(0, 8'h10, '0, '0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule